// File: doc/BRIEF.md
# Core Timer with Watchdog

This block is a free-running timer chain for a small microcontroller. The operating clock first passes a divide-by-four prescaler. It then drives an 8-bit counter that software can read, and after that a run of further divide stages. Software picks one of four taps on those stages to produce a periodic tick. Each time the 8-bit counter wraps it raises a sticky overflow flag, so software can extend the count in memory. Each periodic tick raises a sticky tick flag. Either flag can request an interrupt.

The periodic tick also drives a three-bit watchdog stage that divides it by eight. On the eighth tick with no service write in between, the block emits a one-cycle reset pulse, and that pulse also restarts the whole chain. A service write clears only the three-bit stage. The prescaler, the counter and the tick divider keep their phase, so the guaranteed timeout after a service write is seven tick periods, not eight.

The block sits on a simple register bus: a write strobe, a write byte and a combinational read byte.

Top module: `core_timer_wd`

## Requirements
- R1: The counter read at address 0x09 equals the number of enabled clock edges since the last chain restart, divided by 4 and taken modulo 256. It reads 0x00 after reset.
- R2: The counter is read-only. A write to 0x09 does not change any value that the bus reads back.
- R3: Control bit 7 (read at 0x08) is the overflow flag. It is set on the edge where the counter goes from 0xFF to 0x00 and stays set until a write to 0x08 with bit 7 = 1. If that write falls on an overflow edge, the flag stays set.
- R4: The tick period is 2^(PRE_W+CNT_W+RTI_LO+rate) clock cycles, where rate is control bits 1:0 (2^14 to 2^17 at the defaults). Control bit 6 is the tick flag. It is set on every tick and cleared by a write to 0x08 with bit 6 = 1, and a tick on the same edge wins over the clear.
- R5: `irq` is high exactly when (overflow flag AND bit 5) OR (tick flag AND bit 4). Bits 5 and 4 are written and read at 0x08.
- R6: `wdog_rst` is a single-cycle pulse. With no service writes, the first pulse rises 8 tick periods after reset, which is 8·2^10 cycles at rate 0 when RTI_LO = 0.
- R7: A write to 0x3FF0 with bit 0 = 0 clears only the watchdog stage and leaves the counter phase unchanged. The same write with bit 0 = 1 is ignored.
- R8: After a service write, the pulse follows in no fewer than 7P+1 and no more than 8P cycles, where P is the tick period. Service writes spaced no more than 7P cycles apart prevent every pulse.
- R9: A service write on the same edge as the eighth tick suppresses that pulse.
- R10: In the cycle where `wdog_rst` is high, the counter reads 0x00 and both flags are set.
- R11: After reset, the control register reads 0x00 and `wdog_rst` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for bus_addr, combinational |
| irq | output | 1 | Interrupt request from the enabled flags |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two pairs of events can land on the same edge. A service write can meet the eighth tick of the watchdog stage, and a flag-clear write can meet the overflow event that sets the flag. The bench uses its own cycle-accurate model of the chain phase to wait until the next edge carries the event, then drives the write in that very cycle. It then judges that no pulse appears (the service write wins) and that the flag still reads 1 (the set wins). As a contrast, an ignored watchdog write (bit 0 = 1) placed on the same edge must still let the pulse through.

// File: rtl/ctm_pkg.sv
// Package: shared constants and types for the core timer with watchdog.
// Assumes an 8-bit data bus and a two-bit tick rate select.
package ctm_pkg;
    localparam int DATA_W = 8;
    localparam int RATE_W = 2;
    localparam int NTAP   = 1 << RATE_W;

    // Control register bit positions
    localparam int CTL_OVF_BIT = 7;   // overflow flag, write 1 clears
    localparam int CTL_RTI_BIT = 6;   // tick flag, write 1 clears
    localparam int CTL_OIE_BIT = 5;   // overflow interrupt enable
    localparam int CTL_RIE_BIT = 4;   // tick interrupt enable

    // Default register addresses
    localparam logic [13:0] DEF_CNT_ADDR = 14'h0009;
    localparam logic [13:0] DEF_CTL_ADDR = 14'h0008;
    localparam logic [13:0] DEF_WD_ADDR  = 14'h3FF0;

    typedef struct packed {
        logic              ovf_ie;
        logic              rti_ie;
        logic [RATE_W-1:0] rate;
    } ctm_cfg_t;
endpackage

// File: rtl/ctm_chain.sv
// Module: ctm_chain
// One free-running binary chain. The low PRE_W bits form the prescaler,
// the next CNT_W bits the visible counter, and the top bits the tick
// divider. A tap fires on the edge where every bit below it is one,
// i.e. on the edge where that portion of the chain wraps.
// Assumes: clear is a single-cycle synchronous restart to zero.
module ctm_chain
    import ctm_pkg::*;
#(
    parameter int PRE_W  = 2,
    parameter int CNT_W  = 8,
    parameter int RTI_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_tick,
    output logic              rti_tick
);
    localparam int OVF_W   = PRE_W + CNT_W;
    localparam int BASE_W  = OVF_W + RTI_LO;
    localparam int CHAIN_W = BASE_W + NTAP - 1;

    logic [CHAIN_W-1:0] chain_q;
    logic [NTAP-1:0]    tap_full;

    // Advance the chain by one each cycle; reset or watchdog restart zero it
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_q + 1'b1;
        end
    end

    // One wrap detector per selectable tick rate
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign tap_full[k] = &chain_q[BASE_W+k-1:0];
    end

    assign count    = chain_q[PRE_W +: CNT_W];
    assign ovf_tick = &chain_q[OVF_W-1:0];
    assign rti_tick = tap_full[rate];
endmodule

// File: rtl/ctm_wdog.sv
// Module: ctm_wdog
// Divide-by-2^STAGE_W watchdog stage driven by the periodic tick.
// Expires on the tick that would wrap the stage, unless a service
// write arrives in the same cycle (the service write wins).
// Assumes rti_tick is a one-cycle event.
module ctm_wdog #(
    parameter int STAGE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rti_tick,
    input  logic kick,
    output logic expire,
    output logic rst_pulse
);
    localparam logic [STAGE_W-1:0] LAST = '1;

    logic [STAGE_W-1:0] stage_q;

    assign expire = rti_tick && (stage_q == LAST) && !kick;

    // Count ticks; a service write restarts the stage only
    always_ff @(posedge clk) begin
        if (!rst_n || kick) begin
            stage_q <= '0;
        end else if (rti_tick) begin
            stage_q <= stage_q + 1'b1;
        end
    end

    // Register the expiry into a one-cycle reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= expire;
        end
    end
endmodule

// File: rtl/ctm_regs.sv
// Module: ctm_regs
// Register bus decode: counter read, control register (flags, enables,
// rate), and the watchdog service write. A flag set event wins over a
// clear written in the same cycle. Read data is combinational.
// Assumes bus_wr is high for exactly one cycle per write.
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter int          CNT_W    = 8,
    parameter logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(DEF_CNT_ADDR),
    parameter logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(DEF_CTL_ADDR),
    parameter logic [ADDR_W-1:0] WD_ADDR  = ADDR_W'(DEF_WD_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf_tick,
    input  logic              rti_tick,
    output logic [RATE_W-1:0] rate,
    output logic              kick,
    output logic              ovf_flag,
    output logic              rti_flag,
    output logic              irq
);
    ctm_cfg_t cfg_q;
    logic     ctl_wr;
    logic     unused_rsvd;

    assign ctl_wr      = bus_wr && (bus_addr == CTL_ADDR);
    assign kick        = bus_wr && (bus_addr == WD_ADDR) && !bus_wdata[0];
    assign unused_rsvd = ^bus_wdata[3:2];

    // Hold enables and rate select, loaded by a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctl_wr) begin
            cfg_q.ovf_ie <= bus_wdata[CTL_OIE_BIT];
            cfg_q.rti_ie <= bus_wdata[CTL_RIE_BIT];
            cfg_q.rate   <= bus_wdata[RATE_W-1:0];
        end
    end

    // Sticky overflow flag: set on wrap, clear by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_tick) begin
            ovf_flag <= 1'b1;
        end else if (ctl_wr && bus_wdata[CTL_OVF_BIT]) begin
            ovf_flag <= 1'b0;
        end
    end

    // Sticky tick flag: set on each periodic tick, clear by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rti_flag <= 1'b0;
        end else if (rti_tick) begin
            rti_flag <= 1'b1;
        end else if (ctl_wr && bus_wdata[CTL_RTI_BIT]) begin
            rti_flag <= 1'b0;
        end
    end

    // Select read data by address
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CNT_ADDR) begin
            bus_rdata = DATA_W'(count);
        end else if (bus_addr == CTL_ADDR) begin
            bus_rdata[CTL_OVF_BIT]  = ovf_flag;
            bus_rdata[CTL_RTI_BIT]  = rti_flag;
            bus_rdata[CTL_OIE_BIT]  = cfg_q.ovf_ie;
            bus_rdata[CTL_RIE_BIT]  = cfg_q.rti_ie;
            bus_rdata[RATE_W-1:0]   = cfg_q.rate;
        end
    end

    assign rate = cfg_q.rate;
    assign irq  = (ovf_flag && cfg_q.ovf_ie) || (rti_flag && cfg_q.rti_ie);
endmodule

// File: rtl/core_timer_wd.sv
// Module: core_timer_wd (top)
// Prescaled timer chain with readable counter, selectable periodic
// tick, sticky flags with interrupt request, and a divide-by-eight
// watchdog whose expiry pulses wdog_rst and restarts the chain.
// Assumes a synchronous active-low reset and one-cycle bus writes.
module core_timer_wd
    import ctm_pkg::*;
#(
    parameter int PRE_W  = 2,
    parameter int CNT_W  = 8,
    parameter int RTI_LO = 4,
    parameter int WD_W   = 3,
    parameter int ADDR_W = 14,
    parameter logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(DEF_CNT_ADDR),
    parameter logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(DEF_CTL_ADDR),
    parameter logic [ADDR_W-1:0] WD_ADDR  = ADDR_W'(DEF_WD_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);
    logic [CNT_W-1:0]  count_w;
    logic              ovf_tick_w;
    logic              rti_tick_w;
    logic [RATE_W-1:0] rate_w;
    logic              kick_w;
    logic              expire_w;
    logic              ovf_flag_w;
    logic              rti_flag_w;

    ctm_chain #(
        .PRE_W  (PRE_W),
        .CNT_W  (CNT_W),
        .RTI_LO (RTI_LO)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (expire_w),
        .rate     (rate_w),
        .count    (count_w),
        .ovf_tick (ovf_tick_w),
        .rti_tick (rti_tick_w)
    );

    ctm_wdog #(
        .STAGE_W (WD_W)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .rti_tick  (rti_tick_w),
        .kick      (kick_w),
        .expire    (expire_w),
        .rst_pulse (wdog_rst)
    );

    ctm_regs #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .CNT_ADDR (CNT_ADDR),
        .CTL_ADDR (CTL_ADDR),
        .WD_ADDR  (WD_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_w),
        .ovf_tick  (ovf_tick_w),
        .rti_tick  (rti_tick_w),
        .rate      (rate_w),
        .kick      (kick_w),
        .ovf_flag  (ovf_flag_w),
        .rti_flag  (rti_flag_w),
        .irq       (irq)
    );
endmodule

// File: rtl/ctm_checker.sv
// Module: ctm_checker
// Concurrent properties for core_timer_wd, attached by bind below.
module ctm_checker #(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = '0,
    parameter logic [ADDR_W-1:0] WD_ADDR  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              wd_bit0,
    input logic              ovf_clr_bit,
    input logic              rti_clr_bit,
    input logic [CNT_W-1:0]  count,
    input logic              ovf_flag,
    input logic              rti_flag,
    input logic              irq,
    input logic              wdog_rst
);
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr && addr == CTL_ADDR && ovf_clr_bit)) |=> ovf_flag);

    p_rti_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_flag && !(wr && addr == CTL_ADDR && rti_clr_bit)) |=> rti_flag);

    p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !rti_flag) |-> !irq);

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    p_kick_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == WD_ADDR && !wd_bit0) |=> !wdog_rst);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (count == '0 && ovf_flag && rti_flag));
endmodule

bind core_timer_wd ctm_checker #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .CTL_ADDR (CTL_ADDR),
    .WD_ADDR  (WD_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (bus_addr),
    .wr          (bus_wr),
    .wd_bit0     (bus_wdata[0]),
    .ovf_clr_bit (bus_wdata[7]),
    .rti_clr_bit (bus_wdata[6]),
    .count       (count_w),
    .ovf_flag    (ovf_flag_w),
    .rti_flag    (rti_flag_w),
    .irq         (irq),
    .wdog_rst    (wdog_rst)
);

// File: tb/core_timer_wd_tb_top.sv
// Bench for core_timer_wd at a reduced divider (RTI_LO = 0, tick = 2^(10+rate)).
module core_timer_wd_tb_top;
    localparam logic [13:0] CNT_A = 14'h0009;
    localparam logic [13:0] CTL_A = 14'h0008;
    localparam logic [13:0] WD_A  = 14'h3FF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic        wdog_rst;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int pulse_cnt = 0;
    bit chk_on = 1'b0;

    // Reference model state
    int         m_chain = 0;
    int         m_wd = 0;
    bit         m_pulse = 1'b0;
    bit         m_ovf = 1'b0;
    bit         m_rti = 1'b0;
    bit         m_oie = 1'b0;
    bit         m_rie = 1'b0;
    logic [1:0] m_rate = 2'b00;

    always #2 clk = ~clk;

    core_timer_wd #(.RTI_LO(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    function automatic int period(input logic [1:0] r);
        return 1 << (10 + int'(r));
    endfunction
    function automatic logic [7:0] exp_count();
        return 8'((m_chain >> 2) & 255);
    endfunction
    function automatic logic [7:0] exp_ctl();
        return {m_ovf, m_rti, m_oie, m_rie, 2'b00, m_rate};
    endfunction
    function automatic logic exp_irq();
        return (m_ovf && m_oie) || (m_rti && m_rie);
    endfunction
    function automatic logic [7:0] ctl_word(input bit c_o, input bit c_r, input bit oie,
                                            input bit rie, input logic [1:0] r);
        return {c_o, c_r, oie, rie, 2'b00, r};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Model of the requirements, advanced on each edge
    always @(posedge clk) begin : mdl
        int  per;
        bit  t_o, t_r, kick, xp, ctlw;
        if (!rst_n) begin
            m_chain <= 0; m_wd <= 0; m_pulse <= 0; m_ovf <= 0; m_rti <= 0;
            m_oie <= 0; m_rie <= 0; m_rate <= 2'b00;
        end else begin
            per  = period(m_rate);
            t_o  = (m_chain % 1024) == 1023;
            t_r  = (m_chain % per) == per - 1;
            kick = bus_wr && bus_addr == WD_A && !bus_wdata[0];
            ctlw = bus_wr && bus_addr == CTL_A;
            xp   = t_r && m_wd == 7 && !kick;
            m_chain <= xp ? 0 : m_chain + 1;
            m_wd    <= kick ? 0 : (t_r ? (m_wd + 1) % 8 : m_wd);
            m_pulse <= xp;
            m_ovf   <= t_o ? 1'b1 : ((ctlw && bus_wdata[7]) ? 1'b0 : m_ovf);
            m_rti   <= t_r ? 1'b1 : ((ctlw && bus_wdata[6]) ? 1'b0 : m_rti);
            if (ctlw) begin
                m_oie  <= bus_wdata[5];
                m_rie  <= bus_wdata[4];
                m_rate <= bus_wdata[1:0];
            end
        end
    end

    // Every cycle: reset pulse and interrupt against the model
    always @(negedge clk) begin
        if (chk_on) begin
            #1;
            check(wdog_rst === m_pulse, "R6 wdog_rst", longint'(wdog_rst), longint'(m_pulse));
            check(irq === exp_irq(), "R5 irq", longint'(irq), longint'(exp_irq()));
            if (wdog_rst) pulse_cnt++;
        end
    end

    // Watchdog on the run itself
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL R6 run hung: actual=%0d expected<=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic drive_now(input logic [13:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask
    task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        drive_now(a, d);
    endtask
    task automatic read_chk(input logic [13:0] a, input string req);
        logic [7:0] e;
        bus_addr = a;
        #1;
        e = (a == CNT_A) ? exp_count() : ((a == CTL_A) ? exp_ctl() : 8'h00);
        check(bus_rdata === e, req, longint'(bus_rdata), longint'(e));
    endtask
    // Wait until the next edge carries the final watchdog tick
    task automatic wait_final_tick();
        do begin @(negedge clk); #1; end
        while (!(m_wd == 7 && (m_chain % period(m_rate)) == period(m_rate) - 1));
    endtask
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        int base;
        void'($urandom(32'h5EED_0C01));
        do_reset();
        // R11 / R1: reset state
        #1;
        read_chk(CNT_A, "R1 counter after reset");
        read_chk(CTL_A, "R11 control after reset");
        check(wdog_rst === 1'b0, "R11 wdog_rst after reset", longint'(wdog_rst), 0);
        check(irq === 1'b0, "R11 irq after reset", longint'(irq), 0);
        chk_on = 1'b1;

        // R6: first pulse exactly 8 tick periods after reset (rate 0)
        n = 0;
        do begin @(negedge clk); n++; #1; end while (!wdog_rst && n < 9000);
        check(n == 8 * 1024, "R6 first pulse latency", n, 8 * 1024);
        bus_addr = CNT_A; #1;
        check(bus_rdata === 8'h00, "R10 counter zero on pulse", longint'(bus_rdata), 0);
        bus_addr = CTL_A; #1;
        check(bus_rdata[7:6] === 2'b11, "R10 flags set on pulse", longint'(bus_rdata[7:6]), 3);

        // R1 / R2: counter phase and read-only behaviour
        repeat (37) @(negedge clk);
        read_chk(CNT_A, "R1 counter mid-run");
        bus_write(CNT_A, 8'h5A);
        read_chk(CNT_A, "R2 counter after write");
        read_chk(CTL_A, "R2 control after counter write");

        // R5: enables, then clear flags normally
        bus_write(CTL_A, ctl_word(0, 0, 1, 1, 2'b00));
        read_chk(CTL_A, "R5 enables readback");
        do begin @(negedge clk); #1; end while ((m_chain % 1024) > 900);
        drive_now(CTL_A, ctl_word(1, 1, 1, 0, 2'b00));
        read_chk(CTL_A, "R3 overflow flag cleared");
        check(irq === 1'b0, "R5 irq low after clear", longint'(irq), 0);

        // R3 / R4: set wins over clear written on the same edge
        do begin @(negedge clk); #1; end while ((m_chain % 1024) != 1023);
        drive_now(CTL_A, ctl_word(1, 1, 1, 1, 2'b00));
        #1;
        check(bus_rdata[7] === 1'b1, "R3 set wins over clear", longint'(bus_rdata[7]), 1);
        check(bus_rdata[6] === 1'b1, "R4 set wins over clear", longint'(bus_rdata[6]), 1);

        // R7: an ignored watchdog write on the final tick lets the pulse through
        wait_final_tick();
        base = pulse_cnt;
        drive_now(WD_A, 8'h01);
        #2;
        check(pulse_cnt == base + 1, "R7 bit0=1 write ignored", pulse_cnt - base, 1);

        // R9: a real service write on the final tick suppresses the pulse
        wait_final_tick();
        base = pulse_cnt;
        drive_now(WD_A, 8'h00);
        #2;
        check(pulse_cnt == base, "R9 service write wins", pulse_cnt - base, 0);
        read_chk(CNT_A, "R7 counter phase kept by service write");

        // R8: latency after a service write, two rates
        for (int r = 0; r < 2; r++) begin
            bus_write(CTL_A, ctl_word(0, 0, 1, 1, 2'(r)));
            bus_write(WD_A, 8'h00);
            n = 0;
            do begin @(negedge clk); n++; #1; end while (!wdog_rst && n < 9 * period(2'(r)));
            check(n >= 7 * period(2'(r)) + 1, "R8 latency lower bound", n, 7 * period(2'(r)) + 1);
            check(n <= 8 * period(2'(r)), "R8 latency upper bound", n, 8 * period(2'(r)));
        end

        // R8: regular service writes keep the pulse away
        bus_write(CTL_A, ctl_word(1, 1, 0, 0, 2'b00));
        bus_write(WD_A, 8'h00);
        base = pulse_cnt;
        for (int i = 0; i < 6; i++) begin
            n = (i == 0) ? 7 * 1024 - 2 : int'($urandom_range(1024, 7 * 1024 - 2));
            repeat (n) @(negedge clk);
            bus_write(WD_A, 8'h00);
        end
        check(pulse_cnt == base, "R8 no pulse with service writes", pulse_cnt - base, 0);

        // Random mix of reads, control writes and watchdog writes
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: begin @(negedge clk); read_chk(CNT_A, "R1 random counter read"); end
                1: begin @(negedge clk); read_chk(CTL_A, "R4 random control read"); end
                2: bus_write(CTL_A, 8'($urandom_range(0, 255)) & 8'hF1);
                3: bus_write(WD_A, 8'h00);
                4: bus_write(WD_A, 8'h01 | 8'($urandom_range(0, 255)));
                default: bus_write(CNT_A, 8'($urandom_range(0, 255)));
            endcase
            repeat ($urandom_range(0, 60)) @(negedge clk);
        end
        @(negedge clk);
        read_chk(CNT_A, "R2 counter after random writes");

        chk_on = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule